// File: doc/BRIEF.md
# Faulting Wide-Dividend Integer Divider

This block divides a double-width dividend by a single-width divisor. The dividend is built from two words: the upper word forms bits 63..32 and the lower word forms bits 31..0. The divisor is one 32-bit word. A mode input selects unsigned or two's-complement signed arithmetic. A single-cycle start strobe, sampled while the block is idle, launches an operation. A done strobe later reports the result.

When the divide succeeds, the quotient and the remainder appear on their outputs. Two cases raise a fault flag instead of producing results. The first is a zero divisor. The second is a true quotient that does not fit in one 32-bit word of the selected kind. On a fault the result outputs keep what they held before. Internally the block forms operand magnitudes and runs a restoring shift-subtract over all 64 quotient bits, one bit per cycle by default. It then checks the quotient range and restores the signs. Signed division truncates toward zero, and the remainder takes the sign of the dividend.

Top module: `wide_divider`

## Requirements
- R1: In unsigned mode (signed_mode = 0) with a nonzero divisor, the dividend is {dvd_hi, dvd_lo} as a 64-bit unsigned value. When the quotient is below 2^32, quotient holds the quotient and remainder holds the remainder.
- R2: A start accepted with divisor = 0 raises done and fault together in the cycle after the start, in either mode.
- R3: In unsigned mode, a quotient of 2^32 or more raises fault with done. This covers divisor 1 with a nonzero dvd_hi, and dvd_hi equal to or above the divisor.
- R4: In signed mode (signed_mode = 1), the operands are the two's-complement values {dvd_hi, dvd_lo} and divisor. The quotient is truncated toward zero. The remainder is zero or carries the sign of the dividend.
- R5: In signed mode, a quotient outside -2^31 .. 2^31-1 raises fault. Examples are -2^63 / -1 and +2^31 / 1. A quotient of exactly -2^31 does not fault.
- R6: fault is only ever high together with done. When fault is high, quotient and remainder keep their previous values. Outside a done cycle, quotient and remainder do not change.
- R7: For a nonzero divisor, done (with or without fault) is high for exactly one cycle, 2*W/STEPS + 2 clock cycles after the start edge (66 with the defaults). It is low before that.
- R8: A start pulse during an operation in progress is ignored. The running operation completes with its own result, and no extra done appears.
- R9: After reset, done, fault, quotient and remainder are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch strobe, accepted only while idle |
| signed_mode | input | 1 | 1 selects two's-complement division, 0 selects unsigned |
| dvd_hi | input | W | Upper word of the dividend |
| dvd_lo | input | W | Lower word of the dividend |
| divisor | input | W | Divisor |
| quotient | output | W | Quotient of the last successful divide |
| remainder | output | W | Remainder of the last successful divide |
| fault | output | 1 | Divide fault, high only with done |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest situations to reach are those at the edges of the quotient range. There the 64-bit magnitude path must be exactly right: -2^63 / -1, a quotient of exactly -2^31 against +2^31, and an unsigned dividend whose upper word is one below the divisor. The stimulus drives these operand pairs directly. It then adds a random mix whose upper word is zero, small, a sign extension of the lower word, or arbitrary, so that faults and successes interleave. A zero-divisor start is injected in the middle of a running operation. An accepted start would surface as an immediate done, so the injection exposes any leak in the busy gating.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } wdiv_state_e;
endpackage

// File: rtl/wdiv_rst_sync.sv
module wdiv_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/wdiv_prep.sv
// Operand conditioning: magnitudes, result signs, zero-divisor detect.
module wdiv_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [W-1:0]   dvs,
  input  logic           sgn,
  output logic [2*W-1:0] dvd_mag,
  output logic [W-1:0]   dvs_mag,
  output logic           q_neg,
  output logic           r_neg,
  output logic           dvs_zero
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dvd_raw;
  logic          dvd_neg;
  logic          dvs_neg;

  always_comb begin
    dvd_raw  = {hi, lo};
    dvd_neg  = sgn & hi[W-1];
    dvs_neg  = sgn & dvs[W-1];
    dvd_mag  = dvd_neg ? (~dvd_raw + {{(DW-1){1'b0}}, 1'b1}) : dvd_raw;
    dvs_mag  = dvs_neg ? (~dvs + {{(W-1){1'b0}}, 1'b1}) : dvs;
    q_neg    = dvd_neg ^ dvs_neg;
    r_neg    = dvd_neg;
    dvs_zero = (dvs == '0);
  end
endmodule

// File: rtl/wdiv_step.sv
// One restoring shift-subtract iteration.
module wdiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0]   rem_in,
  input  logic [2*W-1:0] quo_in,
  input  logic [W-1:0]   dvs,
  output logic [W-1:0]   rem_out,
  output logic [2*W-1:0] quo_out
);
  localparam int DW = 2 * W;

  logic [W:0] shifted;
  logic [W:0] trial;
  logic       fits;

  always_comb begin
    shifted = {rem_in, quo_in[DW-1]};
    trial   = shifted - {1'b0, dvs};
    fits    = (shifted >= {1'b0, dvs});
    rem_out = fits ? trial[W-1:0] : shifted[W-1:0];
    quo_out = {quo_in[DW-2:0], fits};
  end
endmodule

// File: rtl/wdiv_post.sv
// Range check of the full quotient magnitude and sign restoration.
module wdiv_post #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] q_mag,
  input  logic [W-1:0]   r_mag,
  input  logic           q_neg,
  input  logic           r_neg,
  input  logic           sgn,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem,
  output logic           ovf
);
  localparam int DW = 2 * W;

  logic upper_any;
  logic low_tail_any;

  always_comb begin
    upper_any    = |q_mag[DW-1:W];
    low_tail_any = |q_mag[W-2:0];
    if (!sgn) begin
      ovf = upper_any;
    end else if (q_neg) begin
      ovf = upper_any | (q_mag[W-1] & low_tail_any);
    end else begin
      ovf = upper_any | q_mag[W-1];
    end
    quo = q_neg ? (~q_mag[W-1:0] + {{(W-1){1'b0}}, 1'b1}) : q_mag[W-1:0];
    rem = r_neg ? (~r_mag + {{(W-1){1'b0}}, 1'b1}) : r_mag;
  end
endmodule

// File: rtl/wide_divider.sv
module wide_divider #(
  parameter int W     = 32,
  parameter int STEPS = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         fault,
  output logic         done
);
  import wdiv_pkg::*;

  localparam int DW    = 2 * W;
  localparam int ITERS = DW / STEPS;
  localparam int CW    = (ITERS > 1) ? $clog2(ITERS) : 1;

  logic rst_q;

  wdiv_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  // operand conditioning
  logic [DW-1:0] p_mag;
  logic [W-1:0]  p_dvs;
  logic          p_qneg;
  logic          p_rneg;
  logic          p_zero;

  wdiv_prep #(.W(W)) u_prep (
    .hi       (dvd_hi),
    .lo       (dvd_lo),
    .dvs      (divisor),
    .sgn      (signed_mode),
    .dvd_mag  (p_mag),
    .dvs_mag  (p_dvs),
    .q_neg    (p_qneg),
    .r_neg    (p_rneg),
    .dvs_zero (p_zero)
  );

  // control
  wdiv_state_e   state_q;
  wdiv_state_e   state_d;
  logic [CW-1:0] cnt_q;
  logic          accept;
  logic          last;
  logic          load_en;
  logic          step_en;
  logic          fin_en;
  logic          zf_en;
  logic          busy;

  assign accept  = (state_q == ST_IDLE) & start;
  assign load_en = accept & ~p_zero;
  assign zf_en   = accept & p_zero;
  assign step_en = (state_q == ST_RUN);
  assign fin_en  = (state_q == ST_FIN);
  assign last    = (cnt_q == CW'(ITERS - 1));
  assign busy    = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (load_en) state_d = ST_RUN;
      ST_RUN:  if (last)    state_d = ST_FIN;
      ST_FIN:               state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt_q <= '0;
    end else if (load_en) begin
      cnt_q <= '0;
    end else if (step_en) begin
      cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  // iterative datapath
  logic [W-1:0]  rem_q;
  logic [DW-1:0] quo_q;
  logic [W-1:0]  dvs_q;
  logic          qneg_q;
  logic          rneg_q;
  logic          sgn_q;

  logic [W-1:0]  rem_c [STEPS+1];
  logic [DW-1:0] quo_c [STEPS+1];

  assign rem_c[0] = rem_q;
  assign quo_c[0] = quo_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    wdiv_step #(.W(W)) u_step (
      .rem_in  (rem_c[g]),
      .quo_in  (quo_c[g]),
      .dvs     (dvs_q),
      .rem_out (rem_c[g+1]),
      .quo_out (quo_c[g+1])
    );
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rem_q <= '0;
      quo_q <= '0;
    end else if (load_en) begin
      rem_q <= '0;
      quo_q <= p_mag;
    end else if (step_en) begin
      rem_q <= rem_c[STEPS];
      quo_q <= quo_c[STEPS];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      dvs_q  <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      sgn_q  <= 1'b0;
    end else if (load_en) begin
      dvs_q  <= p_dvs;
      qneg_q <= p_qneg;
      rneg_q <= p_rneg;
      sgn_q  <= signed_mode;
    end
  end

  // result shaping
  logic [W-1:0] f_quo;
  logic [W-1:0] f_rem;
  logic         f_ovf;

  wdiv_post #(.W(W)) u_post (
    .q_mag (quo_q),
    .r_mag (rem_q),
    .q_neg (qneg_q),
    .r_neg (rneg_q),
    .sgn   (sgn_q),
    .quo   (f_quo),
    .rem   (f_rem),
    .ovf   (f_ovf)
  );

  logic         out_en;
  logic         done_d;
  logic         fault_d;
  logic [W-1:0] quo_out_q;
  logic [W-1:0] rem_out_q;
  logic         done_q;
  logic         fault_q;

  assign out_en  = fin_en & ~f_ovf;
  assign done_d  = zf_en | fin_en;
  assign fault_d = zf_en | (fin_en & f_ovf);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      quo_out_q <= '0;
      rem_out_q <= '0;
    end else if (out_en) begin
      quo_out_q <= f_quo;
      rem_out_q <= f_rem;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  assign quotient  = quo_out_q;
  assign remainder = rem_out_q;
  assign done      = done_q;
  assign fault     = fault_q;
endmodule

// File: rtl/wdiv_checker.sv
module wdiv_checker #(
  parameter int W     = 32,
  parameter int STEPS = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         fault,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  localparam int LAST = (2 * W) / STEPS + 1;
  localparam int CW   = $clog2(LAST + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      run_q <= (divisor != '0);
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == CW'(LAST)) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
      end
    end
  end

  a_r2_zero_div_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && fault));

  a_r6_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  a_r6_hold_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($stable(quotient) && $stable(remainder)));

  a_r6_quiet_outside_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));

  a_r7_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == CW'(LAST)) |-> done);

  a_r7_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != CW'(LAST)) |-> !done);

  a_r8_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

bind wide_divider wdiv_checker #(.W(W), .STEPS(STEPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .start     (start),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/wide_divider_bench.sv
`timescale 1ns/1ps
module wide_divider_bench;
  localparam int W   = 32;
  localparam int LAT = 2 * W + 2;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         signed_mode;
  logic [W-1:0] dvd_hi;
  logic [W-1:0] dvd_lo;
  logic [W-1:0] divisor;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         fault;
  logic         done;

  int total;
  int bad;
  logic [W-1:0] exp_q;
  logic [W-1:0] exp_r;

  wide_divider u_wide_divider (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .dvd_hi      (dvd_hi),
    .dvd_lo      (dvd_lo),
    .divisor     (divisor),
    .quotient    (quotient),
    .remainder   (remainder),
    .fault       (fault),
    .done        (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // behavioural reference: fault flag, quotient, remainder
  task automatic ref_div(input logic sgn, input logic [W-1:0] hi,
                         input logic [W-1:0] lo, input logic [W-1:0] dvs,
                         output bit f, output logic [W-1:0] q,
                         output logic [W-1:0] r);
    f = 1'b0; q = '0; r = '0;
    if (dvs == '0) begin
      f = 1'b1;
    end else if (!sgn) begin
      logic [63:0] ua;
      logic [63:0] ub;
      logic [63:0] uq;
      logic [63:0] ur;
      ua = {hi, lo}; ub = {32'd0, dvs};
      uq = ua / ub; ur = ua % ub;
      f = (uq[63:32] != 0);
      q = uq[31:0]; r = ur[31:0];
    end else begin
      longint a;
      longint b;
      longint qq;
      longint rr;
      int     s;
      a = {hi, lo}; s = dvs; b = s;
      if (a == 64'sh8000_0000_0000_0000 && b == -1) begin
        f = 1'b1;
      end else begin
        qq = a / b; rr = a % b;
        f = (qq > 64'sd2147483647) || (qq < -64'sd2147483648);
        q = qq[31:0]; r = rr[31:0];
      end
    end
  endtask

  task automatic run_op(input string req, input logic sgn, input logic [W-1:0] hi,
                        input logic [W-1:0] lo, input logic [W-1:0] dvs,
                        input bit poke);
    bit           f;
    logic [W-1:0] q;
    logic [W-1:0] r;
    int           lat;
    ref_div(sgn, hi, lo, dvs, f, q, r);
    if (!f) begin exp_q = q; exp_r = r; end
    lat = (dvs == '0) ? 1 : LAT;
    @(negedge clk);
    signed_mode = sgn; dvd_hi = hi; dvd_lo = lo; divisor = dvs; start = 1'b1;
    for (int n = 1; n <= lat; n++) begin
      @(negedge clk);
      if (n == 1) start = 1'b0;
      chk(done == (n == lat), req, "done timing (R7)", {63'd0, done}, {63'd0, n == lat});
      chk(fault == (f && n == lat), req, "fault (R6)", {63'd0, fault}, {63'd0, f && n == lat});
      if (n == lat) begin
        chk(quotient == exp_q, req, "quotient", {32'd0, quotient}, {32'd0, exp_q});
        chk(remainder == exp_r, req, "remainder", {32'd0, remainder}, {32'd0, exp_r});
      end
      if (poke && n == 10) begin
        start = 1'b1; divisor = '0; dvd_hi = 32'h1234_5678; signed_mode = ~sgn;
      end
      if (poke && n == 11) start = 1'b0;
    end
    @(negedge clk);
    chk(!done && !fault, req, "strobe drops (R7)", {62'd0, done, fault}, 64'd0);
  endtask

  initial begin
    #3_000_000;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    exp_q = '0; exp_r = '0;
    start = 1'b0; signed_mode = 1'b0;
    dvd_hi = '0; dvd_lo = '0; divisor = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    chk(!done && !fault, "R9", "done/fault after reset", {62'd0, done, fault}, 64'd0);
    chk(quotient == '0 && remainder == '0, "R9", "results after reset",
        {quotient, remainder}, 64'd0);

    // R1: unsigned basics
    run_op("R1", 1'b0, 32'h0, 32'd100, 32'd7, 1'b0);
    run_op("R1", 1'b0, 32'h3, 32'h1234_5678, 32'h8000_0001, 1'b0);
    run_op("R1", 1'b0, 32'h0, 32'hDEAD_BEEF, 32'h1, 1'b0);
    run_op("R1", 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);

    // R2 with R6: zero divisor, results held
    run_op("R2", 1'b0, 32'h5, 32'h9, 32'h0, 1'b0);
    run_op("R2", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'h0, 1'b0);

    // R3: unsigned overflow
    run_op("R3", 1'b0, 32'h1, 32'h0, 32'h1, 1'b0);
    run_op("R3", 1'b0, 32'h0000_1000, 32'h0, 32'h0000_1000, 1'b0);
    run_op("R3", 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);

    // R4: signed truncation and remainder sign
    run_op("R4", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 1'b0);
    run_op("R4", 1'b1, 32'h0, 32'd7, 32'hFFFF_FFFE, 1'b0);
    run_op("R4", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b0);
    run_op("R4", 1'b1, 32'hFFFF_FFF0, 32'h0, 32'h4000_0000, 1'b0);

    // R5: signed range edges
    run_op("R5", 1'b1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 1'b0);
    run_op("R5", 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 1'b0);
    run_op("R5", 1'b1, 32'h0, 32'h8000_0000, 32'h1, 1'b0);
    run_op("R5", 1'b1, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    run_op("R5", 1'b1, 32'h1, 32'h0, 32'h1, 1'b0);

    // R8: start while busy is ignored
    run_op("R8", 1'b0, 32'h0, 32'd1000, 32'd9, 1'b1);
    run_op("R8", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FC00, 32'd3, 1'b1);

    // mixed random operands covering R1, R3, R4, R5
    for (int k = 0; k < 40; k++) begin
      logic         s;
      logic [W-1:0] hi;
      logic [W-1:0] lo;
      logic [W-1:0] dv;
      int           sel;
      s   = $urandom % 2;
      lo  = $urandom;
      sel = $urandom % 4;
      case (sel)
        0:       hi = '0;
        1:       hi = $urandom % 16;
        2:       hi = {W{lo[W-1]}};
        default: hi = $urandom;
      endcase
      dv = ($urandom % 3 == 0) ? ($urandom % 64) : $urandom;
      run_op(s ? "R4/R5" : "R1/R3", s, hi, lo, dv, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule